// File: doc/BRIEF.md
# Multi-channel PS/2 host port controller

This block is the host side of up to four PS/2 ports that share one shifter. Each channel has a clock line and a data line. Both are open-drain. The block samples them and can pull each one low. Software reaches the block through a small register port. It has a byte-wide data register, a read-only status register and a control register. The control register holds a global enable, a transmit-mode bit and one clock-enable bit per channel.

In receive mode the block watches every enabled channel for a start bit. It serves the lowest-numbered channel that shows one and records that channel in the status register. It then shifts in eight data bits LSB first, checks odd parity and checks the stop bit. In transmit mode it holds the chosen channel's clock low for an inhibit period and then drives a start bit. After that it shifts out the loaded byte, an odd parity bit and a released stop bit, one bit after each falling device clock. It finishes when the device pulls data low as the line-control bit.

After either transfer, the block holds the served channel's clock low until software withdraws that channel. A per-bit timeout abandons a transfer whose device clock stalls.

Top module: `ps2_multi_host`

## Requirements
- R1: After reset the control register (select 2) reads 0, so the block is in receive mode. The status register (select 1) reads 0, and no clock or data line is pulled low. Control bit 0 is the enable, bit 1 is transmit mode, and bits 5:2 are the clock enables of channels 1 to 4.
- R2: A write to the data register (select 0) takes effect only while the transmit bit is 1 and all four clock enables are 0. Any other data write is ignored, and the data register keeps its previous contents.
- R3: In receive mode, a start bit is a falling device clock with data low on an enabled channel. The block then samples data on the next ten falling clock edges of that channel: eight data bits LSB first, then parity, then stop. After the stop bit the byte is readable at select 0 and status bit 1 (end of transfer) is 1.
- R4: Parity is odd. Status bit 2 is 1 exactly when the eight received data bits plus the parity bit hold an even number of ones.
- R5: Status bit 6 is 1 when the received stop bit was sampled low. In transmit mode it is 1 when the line-control bit was sampled high.
- R6: Status bit 0 sets when a transfer starts. Status bits 5:3 name the served channel as 000 none, 001 channel 1, 010 channel 2, 100 channel 3 and 101 channel 4.
- R7: When several enabled channels show a start bit in the same cycle, only the lowest-numbered one is served. Channels whose clock enable is 0 are ignored.
- R8: In transmit mode, setting a clock enable pulls that channel's clock low for INH_CYC cycles. The block then pulls data low as the start bit and releases the clock. After falling clock edges 1 to 8 it drives data bits 0 to 7. After edge 9 it drives the odd parity bit, and after edge 10 it releases data. At edge 11 it sets the end-of-transfer flag.
- R9: Reading the status register clears nothing. Status bits 0 to 2 and 6 keep their value until the next start, which clears bits 1, 2 and 6. The whole status register returns to 0 while the enable and all clock enables are 0.
- R10: If no falling clock arrives on the served channel for TMO_CYC cycles during a transfer, the transfer is abandoned. The end-of-transfer flag stays 0, the lines are released, and a new start bit is accepted.
- R11: After a completed transfer the served channel's clock is pulled low. It stays low until the enable, the transmit bit or that channel's clock enable changes. At most one clock line and one data line are ever pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ps2_clk_i | input | 4 | Sampled level of each channel's clock line |
| ps2_dat_i | input | 4 | Sampled level of each channel's data line |
| ps2_clk_pull_o | output | 4 | 1 pulls the channel's clock line low |
| ps2_dat_pull_o | output | 4 | 1 pulls the channel's data line low |

## Verification
The assertions assume that software changes the control register only through the register port. They also assume that a device never drives a line while the host is pulling it, so the sampled lines are the wired-AND of host and device. The stimulus models each device as an open-drain driver combined with the host pull in exactly that way. Each device clock half period lasts many times the synchronizer depth, so every bit is sampled with settled data. Software always withdraws the clock enable before the next transfer, the same way a driver would.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int NCH  = 4;
  localparam int CH_W = $clog2(NCH);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INH  = 3'd1,
    ST_RX   = 3'd2,
    ST_TX   = 3'd3,
    ST_DONE = 3'd4
  } eng_st_t;

  // active-channel status code: non-contiguous for channels 3 and 4
  function automatic logic [2:0] ach_code(input logic [CH_W-1:0] idx, input logic vld);
    logic [2:0] c;
    case (idx)
      2'd0:    c = 3'b001;
      2'd1:    c = 3'b010;
      2'd2:    c = 3'b100;
      default: c = 3'b101;
    endcase
    return vld ? c : 3'b000;
  endfunction

  function automatic logic [NCH-1:0] ch_onehot(input logic [CH_W-1:0] idx);
    return NCH'(1) << idx;
  endfunction
endpackage

// File: rtl/ps2h_line_sync.sv
module ps2h_line_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] clk_i,
  input  logic [NCH-1:0] dat_i,
  output logic [NCH-1:0] dat_s,
  output logic [NCH-1:0] fall
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [STAGES:0]   cs;
    logic [STAGES-1:0] ds;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cs <= '1;
        ds <= '1;
      end else begin
        cs <= {cs[STAGES-1:0], clk_i[g]};
        ds <= {ds[STAGES-2:0], dat_i[g]};
      end
    end
    assign dat_s[g] = ds[STAGES-1];
    assign fall[g]  = cs[STAGES] & ~cs[STAGES-1];
  end
endmodule

// File: rtl/ps2h_pick.sv
module ps2h_pick
  import ps2h_pkg::*;
(
  input  logic [NCH-1:0]  req,
  output logic            vld,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CH_W'(i);
    end
    vld = |req;
  end
endmodule

// File: rtl/ps2h_engine.sv
module ps2h_engine
  import ps2h_pkg::*;
#(
  parameter int INH_CYC = 10000,
  parameter int TMO_CYC = 25000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            xmt,
  input  logic [NCH-1:0]  clken,
  input  logic            clr_stat,
  input  logic [7:0]      tx_byte,
  input  logic [NCH-1:0]  dat_s,
  input  logic [NCH-1:0]  fall,
  output logic [NCH-1:0]  clk_low,
  output logic [NCH-1:0]  dat_low,
  output logic            sot,
  output logic            eot,
  output logic            perr,
  output logic            rferr,
  output logic            act_vld,
  output logic [CH_W-1:0] act_idx,
  output logic            rx_load,
  output logic [7:0]      rx_byte
);
  localparam int CNT_MAX = (INH_CYC > TMO_CYC) ? INH_CYC : TMO_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  eng_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic             par_bit;
  logic             dlow;
  logic             mode_tx;

  logic [NCH-1:0]  rx_req;
  logic            rx_vld, tx_vld;
  logic [CH_W-1:0] rx_idx, tx_idx;
  logic            dat_a, fall_a;

  assign rx_req = fall & clken & ~dat_s;
  assign dat_a  = dat_s[act_idx];
  assign fall_a = fall[act_idx];

  ps2h_pick u_rx_pick (.req(rx_req), .vld(rx_vld), .idx(rx_idx));
  ps2h_pick u_tx_pick (.req(clken),  .vld(tx_vld), .idx(tx_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      par_bit <= 1'b0;
      dlow    <= 1'b0;
      mode_tx <= 1'b0;
      sot     <= 1'b0;
      eot     <= 1'b0;
      perr    <= 1'b0;
      rferr   <= 1'b0;
      act_vld <= 1'b0;
      act_idx <= '0;
      rx_load <= 1'b0;
      rx_byte <= '0;
    end else begin
      rx_load <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (en && !xmt && rx_vld) begin
            st      <= ST_RX;
            mode_tx <= 1'b0;
            act_idx <= rx_idx;
            act_vld <= 1'b1;
            sot     <= 1'b1;
            eot     <= 1'b0;
            perr    <= 1'b0;
            rferr   <= 1'b0;
            bitn    <= '0;
            cnt     <= '0;
          end else if (en && xmt && tx_vld) begin
            st      <= ST_INH;
            mode_tx <= 1'b1;
            act_idx <= tx_idx;
            act_vld <= 1'b1;
            eot     <= 1'b0;
            perr    <= 1'b0;
            rferr   <= 1'b0;
            sh      <= tx_byte;
            par_bit <= ~^tx_byte;
            cnt     <= '0;
          end
        end
        ST_INH: begin
          if (cnt == CNT_W'(INH_CYC - 1)) begin
            st   <= ST_TX;
            sot  <= 1'b1;
            dlow <= 1'b1;
            cnt  <= '0;
            bitn <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RX, ST_TX: begin
          if (fall_a) begin
            cnt  <= '0;
            bitn <= bitn + 1'b1;
            if (st == ST_RX) begin
              if (bitn < 4'd8) begin
                sh <= {dat_a, sh[7:1]};
              end else if (bitn == 4'd8) begin
                par_bit <= dat_a;
              end else begin
                rx_byte <= sh;
                rx_load <= 1'b1;
                eot     <= 1'b1;
                perr    <= ~(^{sh, par_bit});
                rferr   <= ~dat_a;
                st      <= ST_DONE;
              end
            end else begin
              if (bitn < 4'd8) begin
                dlow <= ~sh[0];
                sh   <= {1'b0, sh[7:1]};
              end else if (bitn == 4'd8) begin
                dlow <= ~par_bit;
              end else if (bitn == 4'd9) begin
                dlow <= 1'b0;
              end else begin
                eot   <= 1'b1;
                rferr <= dat_a;
                st    <= ST_DONE;
              end
            end
          end else if (cnt == CNT_W'(TMO_CYC - 1)) begin
            st   <= ST_IDLE;
            dlow <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase

      if (st != ST_IDLE && (!en || !clken[act_idx] || xmt != mode_tx)) begin
        st   <= ST_IDLE;
        dlow <= 1'b0;
      end

      if (clr_stat) begin
        sot     <= 1'b0;
        eot     <= 1'b0;
        perr    <= 1'b0;
        rferr   <= 1'b0;
        act_vld <= 1'b0;
        act_idx <= '0;
      end
    end
  end

  assign clk_low = (st == ST_INH || st == ST_DONE) ? ch_onehot(act_idx) : '0;
  assign dat_low = dlow ? ch_onehot(act_idx) : '0;
endmodule

// File: rtl/ps2_multi_host.sv
module ps2_multi_host
  import ps2h_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INH_CYC     = 10000,
  parameter int TMO_CYC     = 25000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     reg_sel,
  input  logic           reg_we,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [NCH-1:0] ps2_clk_i,
  input  logic [NCH-1:0] ps2_dat_i,
  output logic [NCH-1:0] ps2_clk_pull_o,
  output logic [NCH-1:0] ps2_dat_pull_o
);
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  logic           ctl_en, ctl_xmt;
  logic [NCH-1:0] ctl_clken;
  logic [7:0]     data_q;
  logic [7:0]     stat_w;
  logic           clr_stat;

  logic [NCH-1:0]  dat_s, fall;
  logic            sot, eot, perr, rferr, act_vld, rx_load;
  logic [CH_W-1:0] act_idx;
  logic [7:0]      rx_byte;

  assign clr_stat = !ctl_en && (ctl_clken == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en    <= 1'b0;
      ctl_xmt   <= 1'b0;
      ctl_clken <= '0;
      data_q    <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_CTL) begin
        ctl_en    <= reg_wdata[0];
        ctl_xmt   <= reg_wdata[1];
        ctl_clken <= reg_wdata[2 +: NCH];
      end
      if (rx_load) begin
        data_q <= rx_byte;
      end else if (reg_we && reg_sel == SEL_DATA && ctl_xmt && ctl_clken == '0) begin
        data_q <= reg_wdata;
      end
    end
  end

  assign stat_w = {1'b0, rferr, ach_code(act_idx, act_vld), perr, eot, sot};

  always_comb begin
    case (reg_sel)
      SEL_DATA: reg_rdata = data_q;
      SEL_STAT: reg_rdata = stat_w;
      SEL_CTL:  reg_rdata = {2'b00, ctl_clken, ctl_xmt, ctl_en};
      default:  reg_rdata = 8'h00;
    endcase
  end

  ps2h_line_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clk_i (ps2_clk_i),
    .dat_i (ps2_dat_i),
    .dat_s (dat_s),
    .fall  (fall)
  );

  ps2h_engine #(.INH_CYC(INH_CYC), .TMO_CYC(TMO_CYC)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_en),
    .xmt      (ctl_xmt),
    .clken    (ctl_clken),
    .clr_stat (clr_stat),
    .tx_byte  (data_q),
    .dat_s    (dat_s),
    .fall     (fall),
    .clk_low  (ps2_clk_pull_o),
    .dat_low  (ps2_dat_pull_o),
    .sot      (sot),
    .eot      (eot),
    .perr     (perr),
    .rferr    (rferr),
    .act_vld  (act_vld),
    .act_idx  (act_idx),
    .rx_load  (rx_load),
    .rx_byte  (rx_byte)
  );
endmodule

// File: rtl/ps2h_checker.sv
module ps2h_checker
  import ps2h_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_en,
  input logic           ctl_xmt,
  input logic [NCH-1:0] ctl_clken,
  input logic [7:0]     stat,
  input logic [NCH-1:0] clk_pull,
  input logic [NCH-1:0] dat_pull
);
  a_r11_one_clock_held: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clk_pull));

  a_r8_one_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dat_pull));

  a_r6_channel_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[5:3] == 3'b000 || stat[5:3] == 3'b001 || stat[5:3] == 3'b010 ||
     stat[5:3] == 3'b100 || stat[5:3] == 3'b101));

  a_r3_end_names_channel: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] |-> stat[5:3] != 3'b000);

  a_r9_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && ctl_clken == '0) |=> stat == 8'h00);

  a_r8_receive_never_drives_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_xmt && !$past(ctl_xmt)) |-> dat_pull == '0);

  a_r1_disabled_releases_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !$past(ctl_en)) |-> (clk_pull == '0 && dat_pull == '0));
endmodule

bind ps2_multi_host ps2h_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_en    (ctl_en),
  .ctl_xmt   (ctl_xmt),
  .ctl_clken (ctl_clken),
  .stat      (stat_w),
  .clk_pull  (ps2_clk_pull_o),
  .dat_pull  (ps2_dat_pull_o)
);

// File: tb/tb_ps2_multi_host.sv
module tb_ps2_multi_host;
  localparam int INH = 40;
  localparam int TMO = 200;
  localparam int HP  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] dclk = 4'hF;
  logic [3:0] ddat = 4'hF;
  logic [3:0] clk_pull, dat_pull;
  wire  [3:0] clk_line = dclk & ~clk_pull;
  wire  [3:0] dat_line = ddat & ~dat_pull;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ps2_multi_host #(.INH_CYC(INH), .TMO_CYC(TMO)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_sel        (reg_sel),
    .reg_we         (reg_we),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .ps2_clk_i      (clk_line),
    .ps2_dat_i      (dat_line),
    .ps2_clk_pull_o (clk_pull),
    .ps2_dat_pull_o (dat_pull)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk);
    reg_sel = sel; reg_wdata = v; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  function automatic int ach_exp(input int idx);
    return (idx < 2) ? (1 << idx) : (4 + idx - 2);
  endfunction

  function automatic int ctl_val(input int en, input int xmt, input int mask);
    return en + 2 * xmt + 4 * mask;
  endfunction

  // device sends bits 0..nbits-1 of an 11-bit frame on every channel in mask
  task automatic dev_send(input logic [3:0] mask, input logic [7:0] b,
                          input bit badpar, input bit stoplow, input int nbits);
    logic [10:0] fr;
    fr = {~stoplow, (~^b) ^ badpar, b, 1'b0};
    for (int k = 0; k < nbits; k++) begin
      ddat = (ddat & ~mask) | (fr[k] ? mask : 4'h0);
      repeat (HP) @(negedge clk);
      dclk = dclk & ~mask;
      repeat (HP) @(negedge clk);
      dclk = dclk | mask;
    end
    ddat = ddat | mask;
    repeat (10) @(negedge clk);
  endtask

  task automatic host_send(input int ch, input logic [7:0] b);
    logic [7:0]  v;
    logic [10:0] got;
    int n;
    int guard;
    got = '0;
    wr(2, 8'(ctl_val(1, 1, 0)));
    wr(0, b);
    wr(2, 8'(ctl_val(1, 1, 1 << ch)));
    guard = 0;
    while (!clk_pull[ch] && guard < 20) begin @(negedge clk); guard++; end
    n = 0;
    while (clk_pull[ch] && n < 10 * INH) begin n++; @(negedge clk); end
    chk("R8 inhibit length", n, INH);
    chk("R8 start bit driven", int'(dat_pull[ch]), 1);
    for (int k = 1; k <= 10; k++) begin
      repeat (HP) @(negedge clk);
      dclk[ch] = 1'b0;
      repeat (HP) @(negedge clk);
      got[k] = dat_line[ch];
      dclk[ch] = 1'b1;
    end
    repeat (HP) @(negedge clk);
    ddat[ch] = 1'b0;
    repeat (2) @(negedge clk);
    dclk[ch] = 1'b0;
    repeat (HP) @(negedge clk);
    dclk[ch] = 1'b1;
    ddat[ch] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 data bits lsb first", int'(got[8:1]), int'(b));
    chk("R8 odd parity bit", int'(got[9]), int'(~^b));
    chk("R8 stop released", int'(got[10]), 1);
    rd(1, v);
    chk("R8 R5 status after transmit", int'(v), 1 + 2 + 8 * ach_exp(ch));
    chk("R11 clock held after transmit", int'(clk_pull), 1 << ch);
    wr(2, 8'(ctl_val(1, 1, 0)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(2, v); chk("R1 control after reset", int'(v), 0);
    rd(1, v); chk("R1 status after reset", int'(v), 0);
    chk("R1 no clock pull", int'(clk_pull), 0);
    chk("R1 no data pull", int'(dat_pull), 0);

    // R3 R6 R11: every byte value, channel rotating
    for (int b = 0; b < 256; b++) begin
      int ch;
      ch = b % 4;
      wr(2, 8'(ctl_val(1, 0, 1 << ch)));
      dev_send(4'(1 << ch), 8'(b), 1'b0, 1'b0, 11);
      rd(0, v); chk("R3 received byte", int'(v), b);
      rd(1, v); chk("R6 R3 status after receive", int'(v), 1 + 2 + 8 * ach_exp(ch));
      if (b % 16 == 0) chk("R11 clock held after receive", int'(clk_pull), 1 << ch);
      wr(2, 8'(ctl_val(1, 0, 0)));
    end

    // R4 parity error, R5 stop low
    for (int b = 3; b < 256; b += 29) begin
      wr(2, 8'(ctl_val(1, 0, 1)));
      dev_send(4'h1, 8'(b), 1'b1, 1'b0, 11);
      rd(1, v); chk("R4 parity error flagged", int'(v), 1 + 2 + 4 + 8);
      wr(2, 8'(ctl_val(1, 0, 0)));
      wr(2, 8'(ctl_val(1, 0, 2)));
      dev_send(4'h2, 8'(b), 1'b0, 1'b1, 11);
      rd(1, v); chk("R5 stop low flagged", int'(v), 1 + 2 + 16 + 64);
      rd(0, v); chk("R5 byte still captured", int'(v), b);
      wr(2, 8'(ctl_val(1, 0, 0)));
    end

    // R7 priority and disabled channels
    wr(2, 8'(ctl_val(1, 0, 15)));
    dev_send(4'hF, 8'h5A, 1'b0, 1'b0, 11);
    rd(1, v); chk("R7 all start, channel 1 served", int'(v[5:3]), 1);
    wr(2, 8'(ctl_val(1, 0, 0)));
    wr(2, 8'(ctl_val(1, 0, 15)));
    dev_send(4'hC, 8'hA7, 1'b0, 1'b0, 11);
    rd(1, v); chk("R7 channels 3 and 4 start, 3 served", int'(v[5:3]), 4);
    wr(2, 8'(ctl_val(1, 0, 0)));
    wr(2, 8'(ctl_val(1, 0, 8)));
    dev_send(4'hF, 8'h3E, 1'b0, 1'b0, 11);
    rd(1, v); chk("R7 only channel 4 enabled", int'(v[5:3]), 5);
    rd(0, v); chk("R7 byte from channel 4", int'(v), 'h3E);

    // R9 sticky status, read does not clear, clear on disable
    wr(2, 8'(ctl_val(1, 0, 0)));
    rd(1, v); rd(1, v2);
    chk("R9 status kept after clock enable cleared", int'(v), 1 + 2 + 40);
    chk("R9 reading does not clear", int'(v2), int'(v));
    wr(2, 8'h00);
    rd(1, v); chk("R9 status cleared when disabled", int'(v), 0);

    // R2 data writes outside the allowed window are ignored
    wr(0, 8'hC3);
    rd(0, v); chk("R2 write in receive mode ignored", int'(v), 'h3E);
    wr(2, 8'(ctl_val(0, 1, 1)));
    wr(0, 8'h96);
    rd(0, v); chk("R2 write with clock enable set ignored", int'(v), 'h3E);
    wr(2, 8'(ctl_val(0, 1, 0)));
    wr(0, 8'h96);
    rd(0, v); chk("R2 write accepted in transmit mode", int'(v), 'h96);

    // R10 timeout
    wr(2, 8'(ctl_val(1, 0, 1)));
    dev_send(4'h1, 8'h00, 1'b0, 1'b0, 4);
    repeat (TMO + 100) @(negedge clk);
    rd(1, v); chk("R10 timeout leaves end flag clear", int'(v), 1 + 8);
    chk("R10 lines released after timeout", int'(clk_pull | dat_pull), 0);
    dev_send(4'h1, 8'hB1, 1'b0, 1'b0, 11);
    rd(0, v); chk("R10 next frame accepted", int'(v), 'hB1);
    rd(1, v); chk("R10 next frame completes", int'(v), 1 + 2 + 8);
    wr(2, 8'h00);

    // R8 transmit sweep
    for (int i = 0; i < 16; i++) begin
      host_send(i % 4, 8'((i * 37 + 5) & 255));
    end
    wr(2, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule